// File: doc/BRIEF.md
# Page Write Latch with Offset Wrap

This block sits between a serial command decoder and a nonvolatile memory array. It collects the data bytes of one write command in a page-sized holding buffer. The buffer position comes from the low bits of a running address. Each accepted byte advances that offset, and the offset wraps inside the page. The upper address bits never move during a command, so a long burst overwrites bytes it stored earlier in the same page.

Nothing reaches the array while bytes are being collected. A commit strobe tells the block that the command ended on a byte boundary. The block then raises a busy flag for a programmable number of clock cycles. Early in that window it walks the page in ascending offset order and presents one array write for each offset that was actually loaded. When the window closes, the block drops busy and pulses a request to clear the external write-enable latch. An abort strobe, which the decoder raises on a bad clock count, throws away the collected bytes without writing anything. Protection decisions are made outside this block.

Top module: `pwl_page_latch`

## Requirements
- R1: During and straight after reset, `busy_o`, `wr_en_o` and `wel_clr_o` are all 0.
- R2: `start_i` loads the page bits `[ADDR_W-1:PAGE_OFF_W]` and the offset bits `[PAGE_OFF_W-1:0]` from `start_addr_i` and empties the buffer. Each byte taken from `byte_vld_i` is stored at the current offset, and the offset then increments by one. The array address written for a byte is {page, offset}.
- R3: The offset increments modulo 2^PAGE_OFF_W (64 by default), so after offset 63 the next byte goes to offset 0 of the same page. The page bits do not change during a command.
- R4: When more bytes arrive than the page holds, a later byte replaces the earlier byte at the same offset. Each offset is written to the array at most once per commit, with its last data.
- R5: No array write (`wr_en_o`) happens while bytes are being collected, before a commit.
- R6: A commit accepted at a clock edge with at least one loaded byte raises `busy_o` in the next cycle. `busy_o` stays high for exactly WRITE_CYCLES cycles.
- R7: During busy, only loaded offsets are written, one per cycle, in ascending offset order. The walk begins at offset 0 in the first busy cycle.
- R8: `wel_clr_o` is high for exactly one cycle, the first cycle after `busy_o` falls. The buffer is empty after completion.
- R9: `abort_i` empties the buffer without any array write. A later commit then finds nothing to write.
- R10: While `busy_o` is high, `commit_i`, `start_i`, `byte_vld_i` and `abort_i` are ignored. The busy length, the array writes, the page, the offset and the buffer contents are all unchanged by them.
- R11: A commit with no loaded bytes is ignored, and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new command and load the start address |
| start_addr_i | input | ADDR_W | Start address of the command |
| byte_vld_i | input | 1 | One data byte is present on `byte_data_i` |
| byte_data_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Command ended validly; begin the internal write |
| abort_i | input | 1 | Command ended invalidly; discard the buffered bytes |
| wr_en_o | output | 1 | Array write strobe |
| wr_addr_o | output | ADDR_W | Array write address |
| wr_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Internal write in progress |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The hardest case to reach from the ports is control traffic that arrives during the busy window. The design must leave the buffer, the page and the offset untouched, and the same strobes must still work once busy falls. The stimulus counts cycles from the commit and injects a second commit, a new start with a byte, and an abort at fixed points inside the window, while the array walk is still running. It then measures the full busy length, checks that the walk delivered exactly the committed bytes, and issues an empty commit. Finally it sends a byte with no new start, whose array address shows that the old page and offset survived. The overflow and wrap cases are reached with bursts that start near the end of a page, and with bursts longer than the page.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
   // Default geometry: 16K x 8 array, 64-byte page
   localparam int DEF_ADDR_W     = 14;
   localparam int DEF_PAGE_OFF_W = 6;
   localparam int DEF_DATA_W     = 8;

   // Counter width helper that never returns zero
   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction
endpackage

// File: rtl/pwl_buffer.sv
module pwl_buffer #(
   parameter int OFF_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [OFF_W-1:0]  ld_off,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              clr,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              any_vld
);
   localparam int ENTRIES = 1 << OFF_W;

   logic [DATA_W-1:0] ent_data [ENTRIES];
   logic [ENTRIES-1:0] ent_vld;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic [DATA_W-1:0] byte_q;
      logic              vld_q;
      logic              hit;

      assign hit = ld_en && (ld_off == OFF_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    vld_q <= 1'b0;
         else if (clr)  vld_q <= 1'b0;
         else if (hit)  vld_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hit && !clr) byte_q <= ld_data;
      end

      assign ent_data[g] = byte_q;
      assign ent_vld[g]  = vld_q;
   end

   assign rd_data = ent_data[rd_off];
   assign rd_vld  = ent_vld[rd_off];
   assign any_vld = |ent_vld;
endmodule

// File: rtl/pwl_timer.sv
module pwl_timer #(
   parameter int CYCLES = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last,
   output logic done
);
   localparam int CNT_W = pwl_pkg::cnt_width(CYCLES);

   logic [CNT_W-1:0] cnt_q;

   assign last = busy && (cnt_q == CNT_W'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt_q <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (last) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
         end
      end
   end
endmodule

// File: rtl/pwl_scan.sv
module pwl_scan #(
   parameter int OFF_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             act,
   output logic [OFF_W-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0;
         idx <= '0;
      end else if (start) begin
         act <= 1'b1;
         idx <= '0;
      end else if (act) begin
         if (idx == {OFF_W{1'b1}}) act <= 1'b0;
         idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/pwl_page_latch.sv
module pwl_page_latch #(
   parameter int ADDR_W       = pwl_pkg::DEF_ADDR_W,
   parameter int PAGE_OFF_W   = pwl_pkg::DEF_PAGE_OFF_W,
   parameter int DATA_W       = pwl_pkg::DEF_DATA_W,
   parameter int WRITE_CYCLES = 1250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_data_i,
   input  logic              commit_i,
   input  logic              abort_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              wel_clr_o
);
   localparam int PAGE_BYTES = 1 << PAGE_OFF_W;
   localparam int PAGE_W     = ADDR_W - PAGE_OFF_W;

   if (PAGE_OFF_W < 1 || PAGE_OFF_W >= ADDR_W) begin : g_bad_geom
      $error("pwl_page_latch: PAGE_OFF_W must lie in 1..ADDR_W-1");
   end
   if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_time
      $error("pwl_page_latch: WRITE_CYCLES must cover one walk of the page");
   end

   logic [PAGE_W-1:0]     page_q;
   logic [PAGE_OFF_W-1:0] off_q;
   logic                  tmr_busy, tmr_last, tmr_done;
   logic                  scan_act;
   logic [PAGE_OFF_W-1:0] scan_idx;
   logic [DATA_W-1:0]     rd_data;
   logic                  rd_vld, any_vld;
   logic                  start_ok, abort_ok, commit_ok, load_ok, buf_clr;

   // Control priority while idle: start, abort, commit, byte
   assign start_ok  = start_i && !tmr_busy;
   assign abort_ok  = abort_i && !tmr_busy && !start_i;
   assign commit_ok = commit_i && !tmr_busy && !start_i && !abort_i && any_vld;
   assign load_ok   = byte_vld_i && !tmr_busy && !start_i && !abort_i && !commit_i;
   assign buf_clr   = start_ok || abort_ok || tmr_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         off_q  <= '0;
      end else if (start_ok) begin
         page_q <= start_addr_i[ADDR_W-1:PAGE_OFF_W];
         off_q  <= start_addr_i[PAGE_OFF_W-1:0];
      end else if (load_ok) begin
         off_q  <= off_q + 1'b1;
      end
   end

   pwl_buffer #(.OFF_W(PAGE_OFF_W), .DATA_W(DATA_W)) buf_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (load_ok),
      .ld_off  (off_q),
      .ld_data (byte_data_i),
      .clr     (buf_clr),
      .rd_off  (scan_idx),
      .rd_data (rd_data),
      .rd_vld  (rd_vld),
      .any_vld (any_vld)
   );

   pwl_timer #(.CYCLES(WRITE_CYCLES)) tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit_ok),
      .busy  (tmr_busy),
      .last  (tmr_last),
      .done  (tmr_done)
   );

   pwl_scan #(.OFF_W(PAGE_OFF_W)) scan_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit_ok),
      .act   (scan_act),
      .idx   (scan_idx)
   );

   assign wr_en_o   = scan_act && rd_vld;
   assign wr_addr_o = {page_q, scan_idx};
   assign wr_data_o = rd_data;
   assign busy_o    = tmr_busy;
   assign wel_clr_o = tmr_done;
endmodule

// File: rtl/pwl_page_latch_chk.sv
module pwl_page_latch_chk #(
   parameter int ADDR_W       = 14,
   parameter int PAGE_OFF_W   = 6,
   parameter int WRITE_CYCLES = 1250000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              commit_i,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic              busy_o,
   input logic              wel_clr_o
);
   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_len <= '0;
      else if (busy_o) busy_len <= busy_len + 1'b1;
      else             busy_len <= '0;
   end

   // R5
   write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> busy_o);

   // R6
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(commit_i));

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_len == 32'(WRITE_CYCLES)));

   // R8
   wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr_o |-> (!busy_o && $past(busy_o)));

   // R3
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |->
         (wr_addr_o[ADDR_W-1:PAGE_OFF_W] == $past(wr_addr_o[ADDR_W-1:PAGE_OFF_W])));
endmodule

bind pwl_page_latch pwl_page_latch_chk #(
   .ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W), .WRITE_CYCLES(WRITE_CYCLES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .commit_i  (commit_i),
   .wr_en_o   (wr_en_o),
   .wr_addr_o (wr_addr_o),
   .busy_o    (busy_o),
   .wel_clr_o (wel_clr_o)
);

// File: tb/pwl_page_latch_tb_top.sv
`timescale 1ns/1ps
module pwl_page_latch_tb_top;
   localparam int WC = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [13:0] start_addr_i = '0;
   logic        byte_vld_i = 1'b0;
   logic [7:0]  byte_data_i = '0;
   logic        commit_i = 1'b0;
   logic        abort_i = 1'b0;
   logic        wr_en_o;
   logic [13:0] wr_addr_o;
   logic [7:0]  wr_data_o;
   logic        busy_o;
   logic        wel_clr_o;

   int n_chk = 0;
   int n_fail = 0;
   int n_writes = 0;
   bit done = 1'b0;

   logic [21:0] exp_q [$];

   // bench-side page model
   logic [7:0] m_page;
   logic [5:0] m_off;
   logic [7:0] m_data [64];
   bit         m_vld [64];

   always #2 clk = ~clk;

   pwl_page_latch #(.WRITE_CYCLES(WC)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .byte_vld_i(byte_vld_i), .byte_data_i(byte_data_i), .commit_i(commit_i),
      .abort_i(abort_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .busy_o(busy_o), .wel_clr_o(wel_clr_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: compare each array write against the scoreboard
   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         n_writes++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5/R7 unexpected array write", int'({wr_addr_o, wr_data_o}), 0);
         end else begin
            logic [21:0] e;
            e = exp_q.pop_front();
            chk({wr_addr_o, wr_data_o} == e, "R7 array write addr/data",
                int'({wr_addr_o, wr_data_o}), int'(e));
         end
      end
   end

   task automatic m_clear();
      for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
   endtask

   task automatic t_start(input logic [13:0] a);
      @(posedge clk); #1 start_i = 1'b1; start_addr_i = a;
      @(posedge clk); #1 start_i = 1'b0;
      m_page = a[13:6]; m_off = a[5:0]; m_clear();
   endtask

   task automatic t_byte(input logic [7:0] d);
      @(posedge clk); #1 byte_vld_i = 1'b1; byte_data_i = d;
      @(posedge clk); #1 byte_vld_i = 1'b0;
      m_data[m_off] = d; m_vld[m_off] = 1'b1; m_off = m_off + 1'b1;
   endtask

   task automatic t_abort();
      @(posedge clk); #1 abort_i = 1'b1;
      @(posedge clk); #1 abort_i = 1'b0;
      m_clear();
   endtask

   // commit, then measure busy length; inject controls inside the window if asked
   task automatic t_commit(input bit inject, input string tag);
      bit any = 1'b0;
      int n = 0;
      int exp_len;
      for (int i = 0; i < 64; i++) begin
         if (m_vld[i]) begin
            any = 1'b1;
            exp_q.push_back({m_page, 6'(i), m_data[i]});
         end
      end
      exp_len = any ? WC : 0;
      @(posedge clk); #1 commit_i = 1'b1;
      @(posedge clk); #1 commit_i = 1'b0;
      for (int k = 0; k < 4 * WC; k++) begin
         @(negedge clk);
         if (!busy_o) break;
         n++;
         if (inject) begin
            case (n)
               4: commit_i = 1'b1;
               5: commit_i = 1'b0;
               6: begin start_i = 1'b1; start_addr_i = 14'h2A10;
                        byte_vld_i = 1'b1; byte_data_i = 8'hEE; end
               7: begin start_i = 1'b0; byte_vld_i = 1'b0; end
               8: abort_i = 1'b1;
               9: abort_i = 1'b0;
               default: ;
            endcase
         end
      end
      chk(n == exp_len, {tag, " R6/R11 busy length"}, n, exp_len);
      if (any) begin
         chk(wel_clr_o == 1'b1, {tag, " R8 wel_clr on busy fall"}, wel_clr_o, 1);
         @(negedge clk);
         chk(wel_clr_o == 1'b0, {tag, " R8 wel_clr one cycle"}, wel_clr_o, 0);
      end else begin
         repeat (3) @(negedge clk);
         chk(busy_o == 1'b0 && wel_clr_o == 1'b0, {tag, " R11 ignored commit"}, busy_o, 0);
      end
      chk(exp_q.size() == 0, {tag, " R7 all writes delivered"}, exp_q.size(), 0);
      m_clear();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
      end
   end

   initial begin
      int w0;
      m_page = '0; m_off = '0; m_clear();
      repeat (3) @(negedge clk);
      // R1
      chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
      chk(wr_en_o == 1'b0, "R1 wr_en in reset", wr_en_o, 0);
      chk(wel_clr_o == 1'b0, "R1 wel_clr in reset", wel_clr_o, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0 && wel_clr_o == 1'b0, "R1 idle after reset", busy_o, 0);

      // R2 R5: plain burst mid-page
      t_start(14'h0123);
      w0 = n_writes;
      for (int i = 0; i < 5; i++) t_byte(8'h10 + 8'(i));
      repeat (4) @(negedge clk);
      chk(n_writes == w0, "R5 no write before commit", n_writes - w0, 0);
      t_commit(1'b0, "R2 burst");

      // R3: wrap across the page end
      t_start(14'h3F3E);
      for (int i = 0; i < 4; i++) t_byte(8'hA0 + 8'(i));
      t_commit(1'b0, "R3 wrap");

      // R4: overflow, 66 bytes from offset 5
      t_start(14'h0A45);
      for (int i = 0; i < 66; i++) t_byte(8'(i * 3 + 1));
      chk(m_data[5] == 8'(64 * 3 + 1), "R4 model overwrite", m_data[5], 64 * 3 + 1);
      t_commit(1'b0, "R4 overflow");

      // R9 R11: abort then commit
      t_start(14'h1000);
      for (int i = 0; i < 3; i++) t_byte(8'h55 + 8'(i));
      w0 = n_writes;
      t_abort();
      t_commit(1'b0, "R9 abort");
      chk(n_writes == w0, "R9 no write after abort", n_writes - w0, 0);

      // R10: controls injected during busy
      t_start(14'h2207);
      for (int i = 0; i < 3; i++) t_byte(8'hC0 + 8'(i));
      t_commit(1'b1, "R10 inject");
      // buffer stayed empty: injected byte not stored
      t_commit(1'b0, "R10 empty after busy");
      // page and offset kept: next byte lands at old page, offset 0x0A
      t_byte(8'h77);
      chk(m_page == 8'h88 && m_off == 6'h0B, "R10 model position", m_off, 6'h0B);
      t_commit(1'b0, "R10 old page");

      done = 1'b1;
      report();
   end
endmodule